// File: doc/BRIEF.md
# Board Control Register Block

This block is a small register file that sits on a simple synchronous read/write port and answers accesses inside a 1 MiB window. It holds the state behind a board's front panel and slow control lines. That state is an eight-LED bar, an eight-character ASCII display, a read-only switch bank, a software reset request, a byte of general-purpose outputs, and a bit-banged two-wire port to a serial EEPROM.

The display can be loaded in two ways. One is a single 32-bit write, which the block converts into eight uppercase hexadecimal characters. The other is a write to one character at a time through registers spaced eight bytes apart. The two-wire port has these parts:

- an output register that drives the clock and data lines;
- an output-enable field and a select bit;
- an input register that returns the stored clock bit together with the live data line from the EEPROM.

A 256-byte sub-range of the window belongs to a neighbouring serial port, so this block does not decode it. Every access that matches no register sets a sticky error flag, which only reset clears.

Top module: `brd_ctrl_regs`

## Requirements
- R1: Only the low 20 bits of `addr_i` select a register. Addresses that differ only in bits 31..20 reach the same register.
- R2: Offsets 0x900..0x9FF and every other offset that matches no register have the following behaviour: a write changes nothing; a read returns 0; `dec_err_o` is set and stays high until reset.
- R3: The LED register at offset 0x408 keeps `wdata_i[7:0]` and drives `led_o`, with bit 7 as the leftmost LED. It reads back in bits 7..0, and bits 31..8 read as 0.
- R4: A write to offset 0x410 replaces all eight characters. Position i (0 = leftmost) gets the uppercase hex ASCII code of nibble `wdata_i[31-4i -: 4]`: values 0-9 map to 0x30-0x39 and values A-F map to 0x41-0x46. Character i appears on `disp_o[8i+7:8i]`.
- R5: The character register for position i (0..7) sits at offset 0x418 + 8*i. A write stores `wdata_i[7:0]` into that position only. A read returns that character in bits 7..0.
- R6: Reset sets every display character to 0x20 (space). It sets all other registers, outputs, `rdata_o` and `dec_err_o` to 0.
- R7: The switch register at offset 0x000 always reads 0. A write to it is accepted without error and has no effect.
- R8: A write of exactly 0x00000042 to offset 0x500 makes `sw_rst_o` high for exactly one cycle. Any other value gives no pulse. A read of this offset returns 0.
- R9: The general-purpose register at 0xA00 keeps 8 bits, the output-enable register at 0xB08 keeps bits 1..0, and the select register at 0xB18 keeps bit 0. Each drives its output port and reads back with its upper bits at 0.
- R10: A write to offset 0xB10 drives `i2c_scl_o` from `wdata_i[1]` and `i2c_sda_o` from `wdata_i[0]`. A read returns these two bits in positions 1..0.
- R11: A read of offset 0xB00 returns the stored clock bit in bit 1 and the `i2c_sda_i` level at the request edge in bit 0. A write to 0xB00 has no effect.
- R12: A write's effect on the outputs appears after the clock edge that accepts the request. Read data is on `rdata_o` for the one cycle after the request edge. In all other cycles `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address; low 20 bits decoded |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| led_o | output | 8 | LED bar, bit 7 leftmost |
| disp_o | output | 64 | Display characters, position i in bits 8i+7..8i |
| sw_rst_o | output | 1 | One-cycle software reset request |
| gpo_o | output | 8 | General-purpose outputs |
| i2c_scl_o | output | 1 | Two-wire clock toward EEPROM |
| i2c_sda_o | output | 1 | Two-wire data toward EEPROM |
| i2c_oe_o | output | 2 | Two-wire output enables |
| i2c_sel_o | output | 1 | Two-wire port select |
| i2c_sda_i | input | 1 | EEPROM data-out line |
| dec_err_o | output | 1 | Sticky decode-error flag |

## Verification
Every write result is due one clock edge after the request edge:

- the LED, display, general-purpose and two-wire outputs;
- the reset pulse;
- the error flag.

Read data is due in the cycle after the request and is 0 again one cycle later. The bench drives each request on a falling edge and holds it through exactly one rising edge. It samples on the next falling edge, which is the first point where both the register update and the read data are settled. The reset pulse is checked both at that falling edge and at the one after it, to pin its one-cycle width.

// File: rtl/brd_pkg.sv
package brd_pkg;

  localparam int WIN_W = 20;

  localparam logic [WIN_W-1:0] OFF_SWITCH  = 20'h00000;
  localparam logic [WIN_W-1:0] OFF_LED     = 20'h00408;
  localparam logic [WIN_W-1:0] OFF_WORD    = 20'h00410;
  localparam logic [WIN_W-1:0] OFF_CHAR0   = 20'h00418;
  localparam logic [WIN_W-1:0] OFF_SRST    = 20'h00500;
  localparam logic [WIN_W-1:0] OFF_GPO     = 20'h00A00;
  localparam logic [WIN_W-1:0] OFF_I2C_IN  = 20'h00B00;
  localparam logic [WIN_W-1:0] OFF_I2C_OE  = 20'h00B08;
  localparam logic [WIN_W-1:0] OFF_I2C_OUT = 20'h00B10;
  localparam logic [WIN_W-1:0] OFF_I2C_SEL = 20'h00B18;
  localparam logic [WIN_W-1:0] OFF_UART_LO = 20'h00900;
  localparam logic [WIN_W-1:0] OFF_UART_HI = 20'h009FF;

  localparam int CHAR_STRIDE_LG = 3;
  localparam logic [7:0] SRST_KEY  = 8'h42;
  localparam logic [7:0] CHAR_BLANK = 8'h20;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_SWITCH,
    RG_LED,
    RG_WORD,
    RG_CHAR,
    RG_SRST,
    RG_GPO,
    RG_I2C_IN,
    RG_I2C_OE,
    RG_I2C_OUT,
    RG_I2C_SEL
  } reg_e;

  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h37 + {4'h0, n};
  endfunction

endpackage

// File: rtl/brd_addr_dec.sv
module brd_addr_dec
  import brd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NCHAR  = 8,
  localparam int IDX_W = $clog2(NCHAR)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_e              rg_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [WIN_W-1:0] CHAR_SPAN = WIN_W'(NCHAR << CHAR_STRIDE_LG);

  logic [WIN_W-1:0] off;
  logic [WIN_W-1:0] char_rel;
  logic             unused_hi;

  assign off       = addr_i[WIN_W-1:0];
  assign char_rel  = off - OFF_CHAR0;
  assign unused_hi = ^addr_i[ADDR_W-1:WIN_W];

  always_comb begin
    rg_o  = RG_NONE;
    idx_o = '0;
    if (off >= OFF_UART_LO && off <= OFF_UART_HI) begin
      rg_o = RG_NONE; // neighbour's sub-range
    end else begin
      case (off)
        OFF_SWITCH:  rg_o = RG_SWITCH;
        OFF_LED:     rg_o = RG_LED;
        OFF_WORD:    rg_o = RG_WORD;
        OFF_SRST:    rg_o = RG_SRST;
        OFF_GPO:     rg_o = RG_GPO;
        OFF_I2C_IN:  rg_o = RG_I2C_IN;
        OFF_I2C_OE:  rg_o = RG_I2C_OE;
        OFF_I2C_OUT: rg_o = RG_I2C_OUT;
        OFF_I2C_SEL: rg_o = RG_I2C_SEL;
        default: begin
          if (off >= OFF_CHAR0 && char_rel < CHAR_SPAN &&
              char_rel[CHAR_STRIDE_LG-1:0] == '0) begin
            rg_o  = RG_CHAR;
            idx_o = char_rel[CHAR_STRIDE_LG +: IDX_W];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/brd_field_reg.sv
module brd_field_reg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= d_i;
  end

endmodule

// File: rtl/brd_disp_buf.sv
module brd_disp_buf
  import brd_pkg::*;
#(
  parameter int NCHAR  = 8,
  localparam int IDX_W = $clog2(NCHAR),
  localparam int WORD_W = 4 * NCHAR
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_we_i,
  input  logic [WORD_W-1:0]  word_i,
  input  logic               chr_we_i,
  input  logic [IDX_W-1:0]   chr_idx_i,
  input  logic [7:0]         chr_i,
  output logic [8*NCHAR-1:0] disp_o
);

  for (genvar g = 0; g < NCHAR; g++) begin : g_pos
    // position 0 is leftmost and takes the top nibble
    logic [3:0] nib;
    logic       hit;
    assign nib = word_i[4*(NCHAR-1-g) +: 4];
    assign hit = chr_we_i && (chr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        disp_o[8*g +: 8] <= CHAR_BLANK;
      else if (word_we_i) disp_o[8*g +: 8] <= hex_ascii(nib);
      else if (hit)       disp_o[8*g +: 8] <= chr_i;
    end
  end

endmodule

// File: rtl/brd_i2c_port.sv
module brd_i2c_port (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       out_we_i,
  input  logic       oe_we_i,
  input  logic       sel_we_i,
  input  logic [1:0] wdata_i,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_o,
  output logic [1:0] oe_o,
  output logic       sel_o,
  output logic [1:0] in_val_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_o <= 1'b0;
      sda_o <= 1'b0;
      oe_o  <= '0;
      sel_o <= 1'b0;
    end else begin
      if (out_we_i) begin
        scl_o <= wdata_i[1];
        sda_o <= wdata_i[0];
      end
      if (oe_we_i)  oe_o  <= wdata_i;
      if (sel_we_i) sel_o <= wdata_i[0];
    end
  end

  // stored bit 1, live EEPROM data in bit 0
  assign in_val_o = {scl_o, sda_i};

endmodule

// File: rtl/brd_ctrl_regs.sv
module brd_ctrl_regs
  import brd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NCHAR = DATA_W / 4,
  localparam int IDX_W = $clog2(NCHAR)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [7:0]         led_o,
  output logic [8*NCHAR-1:0] disp_o,
  output logic               sw_rst_o,
  output logic [7:0]         gpo_o,
  output logic               i2c_scl_o,
  output logic               i2c_sda_o,
  output logic [1:0]         i2c_oe_o,
  output logic               i2c_sel_o,
  input  logic               i2c_sda_i,
  output logic               dec_err_o
);

  reg_e             rg;
  logic [IDX_W-1:0] idx;
  logic             wr, rd;
  logic [1:0]       i2c_in_val;
  logic [7:0]       chr_rd;
  logic [DATA_W-1:0] rd_val;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  brd_addr_dec #(.ADDR_W(ADDR_W), .NCHAR(NCHAR)) u_dec (
    .addr_i (addr_i),
    .rg_o   (rg),
    .idx_o  (idx)
  );

  brd_field_reg #(.W(8)) u_led (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr && rg == RG_LED),
    .d_i    (wdata_i[7:0]),
    .q_o    (led_o)
  );

  brd_field_reg #(.W(8)) u_gpo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr && rg == RG_GPO),
    .d_i    (wdata_i[7:0]),
    .q_o    (gpo_o)
  );

  brd_disp_buf #(.NCHAR(NCHAR)) u_disp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_we_i (wr && rg == RG_WORD),
    .word_i    (wdata_i),
    .chr_we_i  (wr && rg == RG_CHAR),
    .chr_idx_i (idx),
    .chr_i     (wdata_i[7:0]),
    .disp_o    (disp_o)
  );

  brd_i2c_port u_i2c (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .out_we_i (wr && rg == RG_I2C_OUT),
    .oe_we_i  (wr && rg == RG_I2C_OE),
    .sel_we_i (wr && rg == RG_I2C_SEL),
    .wdata_i  (wdata_i[1:0]),
    .sda_i    (i2c_sda_i),
    .scl_o    (i2c_scl_o),
    .sda_o    (i2c_sda_o),
    .oe_o     (i2c_oe_o),
    .sel_o    (i2c_sel_o),
    .in_val_o (i2c_in_val)
  );

  assign chr_rd = disp_o[{idx, 3'b000} +: 8];

  always_comb begin
    rd_val = '0;
    case (rg)
      RG_LED:     rd_val[7:0] = led_o;
      RG_CHAR:    rd_val[7:0] = chr_rd;
      RG_GPO:     rd_val[7:0] = gpo_o;
      RG_I2C_IN:  rd_val[1:0] = i2c_in_val;
      RG_I2C_OE:  rd_val[1:0] = i2c_oe_o;
      RG_I2C_OUT: rd_val[1:0] = {i2c_scl_o, i2c_sda_o};
      RG_I2C_SEL: rd_val[0]   = i2c_sel_o;
      default:    rd_val      = '0; // switch, word, reset, none
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      sw_rst_o  <= 1'b0;
      dec_err_o <= 1'b0;
    end else begin
      rdata_o  <= rd ? rd_val : '0;
      sw_rst_o <= wr && rg == RG_SRST && wdata_i == DATA_W'(SRST_KEY);
      if (req_i && rg == RG_NONE) dec_err_o <= 1'b1;
    end
  end

endmodule

// File: rtl/brd_ctrl_regs_chk.sv
module brd_ctrl_regs_chk
  import brd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [7:0]        led_o,
  input logic              sw_rst_o,
  input logic              dec_err_o,
  input logic              i2c_sda_i
);

  logic [WIN_W-1:0] off;
  assign off = addr_i[WIN_W-1:0];

  // R8
  srst_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_o |=> !sw_rst_o);

  // R8
  srst_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_o |-> $past(req_i && we_i && off == OFF_SRST && wdata_i == DATA_W'(SRST_KEY)));

  // R2
  dec_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_err_o |=> dec_err_o);

  // R2
  uart_range_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && off >= OFF_UART_LO && off <= OFF_UART_HI) |=> dec_err_o);

  // R12
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0);

  // R11
  i2c_in_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && off == OFF_I2C_IN) |=> rdata_o[0] == $past(i2c_sda_i));

  // R3
  led_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && off == OFF_LED) |=> $stable(led_o));

  // R7
  switch_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && off == OFF_SWITCH) |=> rdata_o == '0);

endmodule

bind brd_ctrl_regs brd_ctrl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .led_o     (led_o),
  .sw_rst_o  (sw_rst_o),
  .dec_err_o (dec_err_o),
  .i2c_sda_i (i2c_sda_i)
);

// File: tb/brd_ctrl_regs_test.sv
module brd_ctrl_regs_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  led_o;
  logic [63:0] disp_o;
  logic        sw_rst_o;
  logic [7:0]  gpo_o;
  logic        i2c_scl_o, i2c_sda_o, i2c_sel_o, dec_err_o;
  logic [1:0]  i2c_oe_o;
  logic        i2c_sda_i = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  brd_ctrl_regs uut (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog R12: act=%0d exp<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0; req_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic do_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk_i); req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i); req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic do_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk_i); req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i); req_i = 1'b0; d = rdata_o;
  endtask

  function automatic logic [7:0] exp_hex(input logic [3:0] n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  function automatic logic [63:0] exp_word(input logic [31:0] w);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = exp_hex(w[4*(7-i) +: 4]);
    return r;
  endfunction

  logic [31:0] rv;
  logic [63:0] disp_exp;
  logic [7:0]  led_exp;

  initial begin
    do_reset();
    // R6 reset state
    check("R6 disp", disp_o, {8{8'h20}});
    check("R6 led", {56'b0, led_o}, 64'h0);
    check("R6 gpo", {56'b0, gpo_o}, 64'h0);
    check("R6 i2c", {59'b0, i2c_scl_o, i2c_sda_o, i2c_oe_o, i2c_sel_o}, 64'h0);
    check("R6 srst/err", {62'b0, sw_rst_o, dec_err_o}, 64'h0);
    check("R6 rdata", {32'b0, rdata_o}, 64'h0);

    // R3 LED sweep, upper bits ignored
    for (int v = 0; v < 256; v++) begin
      do_wr(32'h0000_0408, {24'hA5C3E1, 8'(v)});
      check("R3 led_o", {56'b0, led_o}, 64'(v));
      check("R12 rdata after write", {32'b0, rdata_o}, 64'h0);
      if (v % 37 == 0) begin
        do_rd(32'h0000_0408, rv);
        check("R3 led read", {32'b0, rv}, 64'(v));
      end
    end

    // R4 word conversion
    do_wr(32'h0000_0410, 32'h0123_4567);
    check("R4 word 01234567", disp_o, 64'h3736_3534_3332_3130);
    do_wr(32'h0000_0410, 32'h89AB_CDEF);
    check("R4 word 89ABCDEF", disp_o, 64'h4645_4443_4241_3938);
    for (int k = 0; k < 64; k++) begin
      logic [31:0] w;
      w = 32'(k) * 32'h9E37_79B9 ^ 32'h5A5A_0F0F;
      do_wr(32'h0000_0410, w);
      check("R4 word sweep", disp_o, exp_word(w));
    end

    // R5 per-character writes
    do_wr(32'h0000_0410, 32'h0000_0000);
    disp_exp = exp_word(32'h0);
    for (int i = 0; i < 8; i++) begin
      do_wr(32'h418 + 32'(8*i), {24'hFFFF12, 8'(8'h61 + i)});
      disp_exp[8*i +: 8] = 8'(8'h61 + i);
      check("R5 char write", disp_o, disp_exp);
      do_rd(32'h418 + 32'(8*i), rv);
      check("R5 char read", {32'b0, rv}, 64'(8'h61 + i));
    end

    // R1 aliasing above bit 19
    do_wr(32'hFFF0_0408, 32'h0000_003C);
    check("R1 alias led", {56'b0, led_o}, 64'h3C);
    do_rd(32'h1230_0418 + 32'd16, rv);
    check("R1 alias char", {32'b0, rv}, 64'h63);

    // R7 switch
    do_wr(32'h0000_0000, 32'hFFFF_FFFF);
    do_rd(32'h0000_0000, rv);
    check("R7 switch reads 0", {32'b0, rv}, 64'h0);
    check("R7 no error", {63'b0, dec_err_o}, 64'h0);
    check("R7 led untouched", {56'b0, led_o}, 64'h3C);

    // R8 soft reset
    do_wr(32'h0000_0500, 32'h0000_0041);
    check("R8 no pulse 41", {63'b0, sw_rst_o}, 64'h0);
    do_wr(32'h0000_0500, 32'h0000_0142);
    check("R8 no pulse 142", {63'b0, sw_rst_o}, 64'h0);
    do_wr(32'h0000_0500, 32'h0000_0042);
    check("R8 pulse", {63'b0, sw_rst_o}, 64'h1);
    @(negedge clk_i);
    check("R8 pulse width", {63'b0, sw_rst_o}, 64'h0);
    do_rd(32'h0000_0500, rv);
    check("R8 read 0", {32'b0, rv}, 64'h0);

    // R9 gpo, oe, select
    for (int v = 0; v < 256; v++) begin
      do_wr(32'h0000_0A00, {24'h777777, 8'(v)});
      check("R9 gpo", {56'b0, gpo_o}, 64'(v));
    end
    do_rd(32'h0000_0A00, rv);
    check("R9 gpo read", {32'b0, rv}, 64'hFF);
    for (int v = 0; v < 4; v++) begin
      do_wr(32'h0000_0B08, 32'hFFFF_FFFC | 32'(v));
      check("R9 oe", {62'b0, i2c_oe_o}, 64'(v));
      do_rd(32'h0000_0B08, rv);
      check("R9 oe read", {32'b0, rv}, 64'(v));
    end
    for (int v = 0; v < 2; v++) begin
      do_wr(32'h0000_0B18, 32'hFFFF_FFFE | 32'(v));
      check("R9 sel", {63'b0, i2c_sel_o}, 64'(v));
      do_rd(32'h0000_0B18, rv);
      check("R9 sel read", {32'b0, rv}, 64'(v));
    end

    // R10 two-wire outputs
    for (int v = 0; v < 4; v++) begin
      do_wr(32'h0000_0B10, 32'hF0F0_F0F0 | 32'(v));
      check("R10 scl/sda", {62'b0, i2c_scl_o, i2c_sda_o}, 64'(v));
      do_rd(32'h0000_0B10, rv);
      check("R10 read", {32'b0, rv}, 64'(v));
    end

    // R11 input register
    for (int v = 0; v < 4; v++) begin
      do_wr(32'h0000_0B10, {30'b0, v[1], 1'b0});
      i2c_sda_i = v[0];
      do_rd(32'h0000_0B00, rv);
      check("R11 input read", {32'b0, rv}, 64'(v));
    end
    do_wr(32'h0000_0B00, 32'h0000_0000);
    check("R11 write ignored", {62'b0, i2c_scl_o, i2c_sda_o}, 64'h2);
    i2c_sda_i = 1'b0;

    // R12 read data lasts one cycle
    do_rd(32'h0000_0408, rv);
    @(negedge clk_i);
    check("R12 rdata cleared", {32'b0, rdata_o}, 64'h0);

    // R2 decode errors
    led_exp = led_o;
    check("R2 no error yet", {63'b0, dec_err_o}, 64'h0);
    do_wr(32'h0000_0908, 32'h0000_00AA);
    check("R2 uart range led", {56'b0, led_o}, 64'(led_exp));
    check("R2 uart range err", {63'b0, dec_err_o}, 64'h1);
    do_rd(32'h0000_0940, rv);
    check("R2 uart read 0", {32'b0, rv}, 64'h0);
    do_wr(32'h0000_0408, 32'h0000_0011);
    check("R2 err sticky", {63'b0, dec_err_o}, 64'h1);
    do_reset();
    check("R2 err cleared", {63'b0, dec_err_o}, 64'h0);
    do_rd(32'h0000_0404, rv);
    check("R2 unmapped read 0", {32'b0, rv}, 64'h0);
    check("R2 unmapped err", {63'b0, dec_err_o}, 64'h1);
    do_reset();
    do_wr(32'h0000_041C, 32'h0000_0055);
    check("R2 misaligned char", disp_o, {8{8'h20}});
    check("R2 misaligned err", {63'b0, dec_err_o}, 64'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule